// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block turns one NAND operation request into the ordered stream of command and address bytes that a flash device expects. A request carries an opcode, a column value with a present flag, a page value with a present flag, a page mask whose width sets how many row bytes go out, and two static device settings: whether pages are larger than 512 bytes and whether the data bus is 16 bits wide. The block answers with a byte stream in which every byte is tagged as command or address. A downstream engine that produces the real flash strobes takes the bytes over a valid/ready handshake.

Read flavours that the flash cannot do directly are rewritten as full-page reads. A second-half read and a spare-only read both go out as a plain read from column zero. A program setup first runs a complete read of the same page and then sends the data-input opcode. Along with the stream, the block keeps a data pointer and a spare-only flag. Later buffer accesses use these to find the requested bytes inside the full page. When the last byte has been accepted, `done` pulses for one cycle.

Top module: `nand_addr_seq`

## Requirements
- R1: A read (opcode 0x00) sends command 0x00, then column address bytes of value zero, then the row bytes when a page is present. When `big_page` is 1 it also sends command 0x30 last. The data pointer becomes the requested column, or 0 when no column is present.
- R2: For the pass-through opcodes, a present column is sent as its low byte first. Bits [15:8] follow as a second byte only when `big_page` is 1. An absent column produces no column bytes.
- R3: A present page is sent least significant byte first. After each byte, both the page and the mask shift right by 8. Row bytes continue while the shifted mask is non-zero, and at least one row byte is always sent. An absent page produces no row bytes.
- R4: A second-half read (0x01) produces exactly the byte stream of R1. The data pointer becomes the column plus 256.
- R5: A spare-only read (0x50) produces the byte stream of R1 and sets `spare_only` to 1. Every other accepted opcode clears `spare_only`.
- R6: A program setup (0x80) sends the full R1 stream for the same page. It then sends command 0x80, zero-valued column bytes and the row bytes, with no 0x30. The data pointer becomes the column.
- R7: Erase start (0x60), erase confirm (0xD0) and read ID (0x90) are sent unchanged, followed by the R2 column bytes and R3 row bytes. The data pointer becomes the column, or 0 when no column is present.
- R8: Status (0x70) is sent like R7. The data pointer then becomes 1 when `wide_bus` is 1 and 0 otherwise.
- R9: Any other opcode sends no bytes. It pulses `done` in the cycle after it is accepted and leaves `data_ptr` and `spare_only` unchanged.
- R10: `out_is_cmd` is 1 on command bytes and 0 on address bytes.
- R11: While `out_valid` is 1 and `out_ready` is 0, the byte and its tag stay unchanged. `req_ready` is 0 while a stream is in progress.
- R12: `done` is a single-cycle pulse in the cycle after the last byte of a stream is accepted.
- R13: After reset, `req_ready` is 1, and `out_valid`, `done`, `data_ptr` and `spare_only` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request is taken |
| req_cmd | input | 8 | Operation opcode |
| req_col | input | COL_W | Column value |
| req_col_en | input | 1 | Column present |
| req_page | input | ROW_W | Page value |
| req_page_en | input | 1 | Page present |
| req_mask | input | ROW_W | Page mask setting the row byte count |
| big_page | input | 1 | Page size above 512 bytes |
| wide_bus | input | 1 | 16-bit data bus |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Command or address byte |
| out_is_cmd | output | 1 | 1 for a command byte, 0 for an address byte |
| done | output | 1 | Pulse after the stream completes |
| data_ptr | output | COL_W | Data pointer for later buffer access |
| spare_only | output | 1 | Later accesses target the spare area |

## Verification
The bench builds the block with its defaults: a 16-bit column and a 24-bit page and mask. With these widths the high column byte is reachable, and so is every row length from one to three bytes, including the zero-mask case that still sends one byte. The 16-bit pointer can hold the column-plus-256 result of a second-half read. Both page-size settings and both bus widths are driven, so the 0x30 confirm, the two-byte column and both status pointer values all appear, mixed with random downstream stalls.

// File: rtl/nas_pkg.sv
package nas_pkg;

    localparam logic [7:0] OP_READ     = 8'h00;
    localparam logic [7:0] OP_READ_HI  = 8'h01;
    localparam logic [7:0] OP_SPARE    = 8'h50;
    localparam logic [7:0] OP_PROG     = 8'h80;
    localparam logic [7:0] OP_ERASE    = 8'h60;
    localparam logic [7:0] OP_ERASE_GO = 8'hD0;
    localparam logic [7:0] OP_ID       = 8'h90;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_CONFIRM  = 8'h30;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_COL_LO,
        PH_COL_HI,
        PH_ROW,
        PH_CONF
    } phase_e;

    typedef enum logic [1:0] {
        PTR_COL,
        PTR_COL_PLUS,
        PTR_STAT
    } ptr_sel_e;

    typedef struct packed {
        logic [7:0] first_cmd;
        logic       col_zero;
        logic       confirm;
        logic       second;
        logic       drop;
        logic       spare;
        ptr_sel_e   ptr_sel;
    } plan_t;

    function automatic plan_t plan_for(input logic [7:0] op, input logic big);
        plan_t p;
        p           = '0;
        p.ptr_sel   = PTR_COL;
        p.first_cmd = op;
        unique case (op)
            OP_READ, OP_READ_HI, OP_SPARE, OP_PROG: begin
                p.first_cmd = OP_READ;
                p.col_zero  = 1'b1;
                p.confirm   = big;
                p.second    = (op == OP_PROG);
                p.spare     = (op == OP_SPARE);
                p.ptr_sel   = (op == OP_READ_HI) ? PTR_COL_PLUS : PTR_COL;
            end
            OP_ERASE, OP_ERASE_GO, OP_ID: p.ptr_sel = PTR_COL;
            OP_STATUS:                    p.ptr_sel = PTR_STAT;
            default:                      p.drop    = 1'b1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/nas_decode.sv
module nas_decode
    import nas_pkg::*;
#(
    parameter int COL_W = 16
) (
    input  logic [7:0]       op,
    input  logic             big,
    input  logic [COL_W-1:0] col_in,
    input  logic             col_en_in,
    output plan_t            plan,
    output logic [COL_W-1:0] col_send,
    output logic             col_send_en
);
    always_comb begin
        plan        = plan_for(op, big);
        col_send    = plan.col_zero ? '0 : col_in;
        col_send_en = plan.col_zero | col_en_in;
    end
endmodule

// File: rtl/nas_pointer.sv
module nas_pointer
    import nas_pkg::*;
#(
    parameter int COL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  ptr_sel_e         sel,
    input  logic             spare_in,
    input  logic [COL_W-1:0] col,
    input  logic             col_en,
    input  logic             wide,
    output logic [COL_W-1:0] data_ptr,
    output logic             spare_only
);
    localparam logic [COL_W-1:0] HALF_STEP = COL_W'(256);

    logic [COL_W-1:0] base, nxt;

    always_comb begin
        base = col_en ? col : '0;
        unique case (sel)
            PTR_COL_PLUS: nxt = base + HALF_STEP;
            PTR_STAT:     nxt = {{(COL_W-1){1'b0}}, wide};
            default:      nxt = base;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_ptr   <= '0;
            spare_only <= 1'b0;
        end else if (load) begin
            data_ptr   <= nxt;
            spare_only <= spare_in;
        end
    end

    // R9: pointer state moves only when a request is taken
    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(data_ptr) && $stable(spare_only)));
endmodule

// File: rtl/nas_emitter.sv
module nas_emitter
    import nas_pkg::*;
#(
    parameter int COL_W = 16,
    parameter int ROW_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  plan_t            plan,
    input  logic [COL_W-1:0] col,
    input  logic             col_en,
    input  logic [ROW_W-1:0] page,
    input  logic             page_en,
    input  logic [ROW_W-1:0] mask,
    input  logic             big,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic             out_is_cmd,
    output logic             busy,
    output logic             last_fire
);
    phase_e           phase, nxt;
    logic [7:0]       cmd_q;
    logic [COL_W-1:0] col_q;
    logic             col_en_q, page_en_q, big_q, conf_q, second_q;
    logic [ROW_W-1:0] page_sh, mask_sh, page_q, mask_q;
    logic             fire;
    phase_e           tail;

    assign out_valid = (phase != PH_IDLE);
    assign busy      = out_valid;
    assign fire      = out_valid & out_ready;

    always_comb begin
        tail = conf_q ? PH_CONF : (second_q ? PH_CMD : PH_IDLE);
        nxt  = phase;
        unique case (phase)
            PH_CMD:    nxt = col_en_q ? PH_COL_LO : (page_en_q ? PH_ROW : tail);
            PH_COL_LO: nxt = big_q ? PH_COL_HI : (page_en_q ? PH_ROW : tail);
            PH_COL_HI: nxt = page_en_q ? PH_ROW : tail;
            PH_ROW:    nxt = ((mask_sh >> 8) != '0) ? PH_ROW : tail;
            PH_CONF:   nxt = second_q ? PH_CMD : PH_IDLE;
            default:   nxt = PH_IDLE;
        endcase
    end

    assign last_fire = fire && (nxt == PH_IDLE);

    always_comb begin
        out_is_cmd = (phase == PH_CMD) || (phase == PH_CONF);
        unique case (phase)
            PH_CMD:    out_byte = cmd_q;
            PH_COL_LO: out_byte = col_q[7:0];
            PH_COL_HI: out_byte = 8'(col_q >> 8);
            PH_ROW:    out_byte = page_sh[7:0];
            PH_CONF:   out_byte = OP_CONFIRM;
            default:   out_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cmd_q     <= '0;
            col_q     <= '0;
            col_en_q  <= 1'b0;
            page_en_q <= 1'b0;
            big_q     <= 1'b0;
            conf_q    <= 1'b0;
            second_q  <= 1'b0;
            page_sh   <= '0;
            mask_sh   <= '0;
            page_q    <= '0;
            mask_q    <= '0;
        end else if (start) begin
            phase     <= PH_CMD;
            cmd_q     <= plan.first_cmd;
            col_q     <= col;
            col_en_q  <= col_en;
            page_en_q <= page_en;
            big_q     <= big;
            conf_q    <= plan.confirm;
            second_q  <= plan.second;
            page_sh   <= page;
            mask_sh   <= mask;
            page_q    <= page;
            mask_q    <= mask;
        end else if (fire) begin
            phase <= nxt;
            if (phase == PH_ROW) begin
                page_sh <= page_sh >> 8;
                mask_sh <= mask_sh >> 8;
            end
            if (phase == PH_CONF)
                conf_q <= 1'b0;
            if (nxt == PH_CMD) begin
                cmd_q    <= OP_PROG;
                col_q    <= '0;
                col_en_q <= 1'b1;
                conf_q   <= 1'b0;
                second_q <= 1'b0;
                page_sh  <= page_q;
                mask_sh  <= mask_q;
            end
        end
    end

    // R11: a stalled byte and its tag are held
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_byte) && $stable(out_is_cmd)));

    // R3: the next row byte is the following page byte
    a_r3_row_order: assert property (@(posedge clk) disable iff (rst)
        (fire && phase == PH_ROW && nxt == PH_ROW) |=>
            (out_byte == 8'($past(page_sh) >> 8)));
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
    import nas_pkg::*;
#(
    parameter int COL_W = 16,
    parameter int ROW_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_cmd,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_col_en,
    input  logic [ROW_W-1:0] req_page,
    input  logic             req_page_en,
    input  logic [ROW_W-1:0] req_mask,
    input  logic             big_page,
    input  logic             wide_bus,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic             out_is_cmd,
    output logic             done,
    output logic [COL_W-1:0] data_ptr,
    output logic             spare_only
);
    plan_t            plan;
    logic [COL_W-1:0] col_send;
    logic             col_send_en;
    logic             busy, last_fire, accept, done_q;

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign done      = done_q;

    nas_decode #(.COL_W(COL_W)) u_decode (
        .op          (req_cmd),
        .big         (big_page),
        .col_in      (req_col),
        .col_en_in   (req_col_en),
        .plan        (plan),
        .col_send    (col_send),
        .col_send_en (col_send_en)
    );

    nas_emitter #(.COL_W(COL_W), .ROW_W(ROW_W)) u_emit (
        .clk        (clk),
        .rst        (rst),
        .start      (accept && !plan.drop),
        .plan       (plan),
        .col        (col_send),
        .col_en     (col_send_en),
        .page       (req_page),
        .page_en    (req_page_en),
        .mask       (req_mask),
        .big        (big_page),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_byte   (out_byte),
        .out_is_cmd (out_is_cmd),
        .busy       (busy),
        .last_fire  (last_fire)
    );

    nas_pointer #(.COL_W(COL_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .load       (accept && !plan.drop),
        .sel        (plan.ptr_sel),
        .spare_in   (plan.spare),
        .col        (req_col),
        .col_en     (req_col_en),
        .wide       (wide_bus),
        .data_ptr   (data_ptr),
        .spare_only (spare_only)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= last_fire || (accept && plan.drop);
    end

    // R11: no new request while streaming
    a_r11_busy: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready);

    // R12: done comes only once the stream has drained
    a_r12_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);
endmodule

// File: tb/nand_addr_seq_tb.sv
module nand_addr_seq_tb;
    localparam int COL_W = 16;
    localparam int ROW_W = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [7:0]       req_cmd = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_col_en = 1'b0;
    logic [ROW_W-1:0] req_page = '0;
    logic             req_page_en = 1'b0;
    logic [ROW_W-1:0] req_mask = '0;
    logic             big_page = 1'b0;
    logic             wide_bus = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [7:0]       out_byte;
    logic             out_is_cmd;
    logic             done;
    logic [COL_W-1:0] data_ptr;
    logic             spare_only;

    always #2.5 clk = ~clk;

    nand_addr_seq #(.COL_W(COL_W), .ROW_W(ROW_W)) u_dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    logic [8:0]       exp_q [0:63];
    int               exp_n;
    logic [COL_W-1:0] exp_ptr = '0;
    logic             exp_spare = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input bit c, input logic [7:0] b);
        if (exp_n < 64) exp_q[exp_n] = {c, b};
        exp_n++;
    endtask

    task automatic push_seq(input logic [7:0] op, input logic [15:0] cv, input bit cen,
                            input logic [ROW_W-1:0] pg, input bit pen,
                            input logic [ROW_W-1:0] mk, input bit big, input bit conf);
        logic [ROW_W-1:0] p, m;
        push(1'b1, op);
        if (cen) begin
            push(1'b0, cv[7:0]);
            if (big) push(1'b0, cv[15:8]);
        end
        if (pen) begin
            p = pg; m = mk;
            do begin
                push(1'b0, p[7:0]);
                p = p >> 8;
                m = m >> 8;
            end while (m != '0);
        end
        if (conf) push(1'b1, 8'h30);
    endtask

    task automatic build_exp(input logic [7:0] op, input logic [15:0] cv, input bit cen,
                             input logic [ROW_W-1:0] pg, input bit pen,
                             input logic [ROW_W-1:0] mk, input bit big, input bit wide);
        logic [15:0] base;
        exp_n = 0;
        base  = cen ? cv : 16'h0;
        case (op)
            8'h00, 8'h01, 8'h50, 8'h80: begin
                push_seq(8'h00, 16'h0, 1'b1, pg, pen, mk, big, big);
                if (op == 8'h80) push_seq(8'h80, 16'h0, 1'b1, pg, pen, mk, big, 1'b0);
                exp_ptr   = (op == 8'h01) ? base + 16'd256 : base;
                exp_spare = (op == 8'h50);
            end
            8'h60, 8'hD0, 8'h90, 8'h70: begin
                push_seq(op, cv, cen, pg, pen, mk, big, 1'b0);
                exp_ptr   = (op == 8'h70) ? {15'h0, wide} : base;
                exp_spare = 1'b0;
            end
            default: ;
        endcase
    endtask

    task automatic run_req(input string tag, input logic [7:0] op, input logic [15:0] cv,
                           input bit cen, input logic [ROW_W-1:0] pg, input bit pen,
                           input logic [ROW_W-1:0] mk, input bit big, input bit wide,
                           input int stall_pct);
        int  got;
        bit  seen_done, held;
        logic [8:0] held_v;
        build_exp(op, cv, cen, pg, pen, mk, big, wide);
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "req_ready when idle", req_ready, 1);
        req_cmd = op; req_col = cv; req_col_en = cen; req_page = pg;
        req_page_en = pen; req_mask = mk; big_page = big; wide_bus = wide;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; seen_done = 0; held = 0; held_v = '0;
        for (int g = 0; g < 400; g++) begin
            if (done) begin seen_done = 1; break; end
            if (out_valid && g == 0)
                check(req_ready == 1'b0, "R11", "req_ready while busy", req_ready, 0);
            if (held) begin
                check(out_valid && {out_is_cmd, out_byte} == held_v, "R11",
                      "stalled byte held", {out_valid, out_is_cmd, out_byte}, {1'b1, held_v});
            end
            out_ready = (($urandom % 100) >= stall_pct);
            held = out_valid && !out_ready;
            held_v = {out_is_cmd, out_byte};
            if (out_valid && out_ready) begin
                if (got < exp_n && got < 64) begin
                    check(out_is_cmd == exp_q[got][8], "R10", "tag", out_is_cmd, exp_q[got][8]);
                    check(out_byte == exp_q[got][7:0], tag, "byte", out_byte, exp_q[got][7:0]);
                end
                got++;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(seen_done, "R12", "done seen", seen_done, 1);
        check(got == exp_n, tag, "byte count", got, exp_n);
        check(data_ptr == exp_ptr, tag, "data_ptr", data_ptr, exp_ptr);
        check(spare_only == exp_spare, "R5", "spare_only", spare_only, exp_spare);
        @(negedge clk);
        check(done == 1'b0, "R12", "done single pulse", done, 0);
    endtask

    function automatic logic [7:0] pick_op(input int k);
        case (k % 10)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h50; 3: return 8'h80;
            4: return 8'h60; 5: return 8'hD0; 6: return 8'h90; 7: return 8'h70;
            8: return 8'h35;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [ROW_W-1:0] pick_mask(input int k);
        case (k % 5)
            0: return 24'h000000; 1: return 24'h0000FF; 2: return 24'h00FFFF;
            3: return 24'h01FFFF;
            default: return 24'hFFFFFF;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R13 reset state
        check(req_ready == 1'b1, "R13", "req_ready", req_ready, 1);
        check(out_valid == 1'b0, "R13", "out_valid", out_valid, 0);
        check(done == 1'b0, "R13", "done", done, 0);
        check(data_ptr == '0, "R13", "data_ptr", data_ptr, 0);
        check(spare_only == 1'b0, "R13", "spare_only", spare_only, 0);

        // R1 read on a large page with confirm
        run_req("R1", 8'h00, 16'h1234, 1, 24'h012345, 1, 24'h00FFFF, 1, 0, 0);
        run_req("R1", 8'h00, 16'h0040, 1, 24'h000077, 1, 24'h0000FF, 0, 0, 30);
        // R2 column bytes for pass-through opcodes
        run_req("R2", 8'h90, 16'hAB12, 1, 24'h0, 0, 24'h0, 0, 0, 0);
        run_req("R2", 8'h90, 16'hAB12, 1, 24'h0, 0, 24'h0, 1, 0, 50);
        run_req("R2", 8'h60, 16'h0000, 0, 24'h00BEEF, 1, 24'h00FFFF, 1, 0, 0);
        // R3 row byte counts
        run_req("R3", 8'h60, 16'h0, 0, 24'h0000AB, 1, 24'h000000, 0, 0, 0);
        run_req("R3", 8'hD0, 16'h0, 0, 24'hC0FFEE, 1, 24'hFFFFFF, 0, 0, 40);
        run_req("R3", 8'h90, 16'h0, 0, 24'h123456, 0, 24'hFFFFFF, 0, 0, 0);
        // R4 second-half read
        run_req("R4", 8'h01, 16'h0005, 1, 24'h000100, 1, 24'h0001FF, 1, 0, 0);
        // R5 spare-only then cleared
        run_req("R5", 8'h50, 16'h0010, 1, 24'h000033, 1, 24'h0000FF, 0, 0, 0);
        run_req("R7", 8'h60, 16'h0, 0, 24'h000044, 1, 24'h0000FF, 0, 0, 0);
        // R6 program setup
        run_req("R6", 8'h80, 16'h0801, 1, 24'h00ABCD, 1, 24'h00FFFF, 1, 0, 25);
        run_req("R6", 8'h80, 16'h0020, 1, 24'h000009, 1, 24'h000000, 0, 0, 0);
        // R8 status on both bus widths
        run_req("R8", 8'h70, 16'h0, 0, 24'h0, 0, 24'h0, 1, 1, 0);
        run_req("R8", 8'h70, 16'h0, 0, 24'h0, 0, 24'h0, 0, 0, 0);
        // R9 dropped opcode after a known pointer
        run_req("R7", 8'h90, 16'h00C3, 1, 24'h0, 0, 24'h0, 0, 0, 0);
        run_req("R9", 8'h35, 16'hFFFF, 1, 24'hFFFFFF, 1, 24'hFFFFFF, 1, 1, 0);

        for (int t = 0; t < 200; t++) begin
            logic [7:0] op;
            op = pick_op(int'($urandom % 10));
            run_req(op == 8'h00 ? "R1" : op == 8'h01 ? "R4" : op == 8'h50 ? "R5" :
                    op == 8'h80 ? "R6" : op == 8'h70 ? "R8" :
                    (op == 8'h35 || op == 8'hFF) ? "R9" : "R7",
                    op, 16'($urandom), 1'($urandom), 24'($urandom), 1'($urandom),
                    pick_mask(int'($urandom % 5)), 1'($urandom), 1'($urandom),
                    int'($urandom % 60));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule